// File: doc/BRIEF.md
# Flash ECC Fault Status and Interrupt Controller

This block sits beside the ECC decoder of a non-volatile memory controller. On every array read it takes the decoder's verdict: a read strobe plus single-bit and double-bit fault indications. It records the verdict in two sticky status flags and turns the flags into level interrupt requests. It also takes the command-complete flag from the command sequencer and turns it into a command interrupt request.

Software reaches three byte-wide registers through a simple write-strobe and address bus. The read data path is combinational. A control register enables the command interrupt and can suppress single-bit fault reporting. The same register holds two force bits that make every array read look faulty, so that fault handlers can be tested without a damaged array. An enable register gates the two fault interrupts. A status register holds the two flags, and software clears them by writing 1.

Top module: `nvm_fault_irq_ctrl`

## Requirements
- R1: Address 0 is the control register. Bit 7 is command interrupt enable, bit 4 is ignore-single-fault, bit 1 is force-double-fault and bit 0 is force-single-fault. Bits 6, 5, 3 and 2 read 0 and ignore writes, so writing 0xFF reads back 0x93.
- R2: While `rst` is high at a clock edge, all control bits, enables, flags and interrupt outputs become 0.
- R3: `irq_cmd` equals `cmd_done` AND command interrupt enable as sampled at the previous clock edge. When the enable is 0, the request is 0.
- R4: A read strobe with `ecc_single` high sets the single-fault flag when ignore-single-fault is 0, and leaves it unchanged when ignore-single-fault is 1. Fault inputs without `rd_strobe` have no effect.
- R5: With force-double-fault set, every read strobe sets the double-fault flag, whatever the ECC inputs. With force-single-fault set, every read strobe sets the single-fault flag, whatever the ECC inputs and even when ignore-single-fault is 1.
- R6: Address 2 is the status register, with the double-fault flag at bit 1 and the single-fault flag at bit 0. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and the other bits read 0.
- R7: `irq_single` equals single-fault flag AND its enable, and `irq_double` equals double-fault flag AND its enable, each taken one clock earlier.
- R8: Address 1 is the enable register, with the double-fault interrupt enable at bit 1 and the single-fault interrupt enable at bit 0. The other bits read 0.
- R9: When a hardware set and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R10: A force bit stays set across any number of reads until software writes 0 to it.
- R11: Address 3 is unused. Writes to it change nothing, and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rd_strobe | input | 1 | One array read completes this cycle |
| ecc_single | input | 1 | ECC found a single-bit fault on this read |
| ecc_double | input | 1 | ECC found a double-bit fault on this read |
| cmd_done | input | 1 | Command-complete flag from the sequencer |
| irq_cmd | output | 1 | Command-complete interrupt request |
| irq_single | output | 1 | Single-bit fault interrupt request |
| irq_double | output | 1 | Double-bit fault interrupt request |

## Verification
The bench builds the block with the default `ADDR_W` of 2. This gives a four-entry address space with exactly one unused slot, so the decode of an unmapped address can be reached. Random traffic mixes sparse register writes, including writes that toggle the force and ignore bits, with dense read strobes. This makes collisions between a flag being set and the same flag being cleared, and force bits overriding the ignore bit, occur many times.

// File: rtl/nvm_fault_pkg.sv
package nvm_fault_pkg;

    localparam int REG_W = 8;

    // register slots
    localparam int CTRL_SLOT = 0;
    localparam int EN_SLOT   = 1;
    localparam int STAT_SLOT = 2;

    // control register fields
    localparam int CMD_IE_BIT   = 7;
    localparam int IGN_SGL_BIT  = 4;
    localparam int FORCE_DB_BIT = 1;
    localparam int FORCE_SG_BIT = 0;

    // enable / status fields
    localparam int DBL_BIT = 1;
    localparam int SGL_BIT = 0;

    // interrupt lines
    localparam int IRQ_N   = 3;
    localparam int IRQ_CMD = 0;
    localparam int IRQ_SGL = 1;
    localparam int IRQ_DBL = 2;

    typedef struct packed {
        logic cmd_ie;
        logic ign_single;
        logic force_double;
        logic force_single;
    } ctrl_cfg_t;

    typedef struct packed {
        logic dbl;
        logic sgl;
    } fault_pair_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_EN,
        SEL_STAT
    } reg_sel_t;

    function automatic reg_sel_t reg_sel(input int unsigned a);
        case (a)
            CTRL_SLOT: return SEL_CTRL;
            EN_SLOT:   return SEL_EN;
            STAT_SLOT: return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_cfg_t ctrl_from_byte(input logic [REG_W-1:0] b);
        ctrl_cfg_t c;
        c.cmd_ie       = b[CMD_IE_BIT];
        c.ign_single   = b[IGN_SGL_BIT];
        c.force_double = b[FORCE_DB_BIT];
        c.force_single = b[FORCE_SG_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_byte(input ctrl_cfg_t c);
        logic [REG_W-1:0] b;
        b = '0;
        b[CMD_IE_BIT]   = c.cmd_ie;
        b[IGN_SGL_BIT]  = c.ign_single;
        b[FORCE_DB_BIT] = c.force_double;
        b[FORCE_SG_BIT] = c.force_single;
        return b;
    endfunction

    function automatic fault_pair_t pair_from_byte(input logic [REG_W-1:0] b);
        fault_pair_t p;
        p.dbl = b[DBL_BIT];
        p.sgl = b[SGL_BIT];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pair_to_byte(input fault_pair_t p);
        logic [REG_W-1:0] b;
        b = '0;
        b[DBL_BIT] = p.dbl;
        b[SGL_BIT] = p.sgl;
        return b;
    endfunction

endpackage

// File: rtl/nvm_reg_bank.sv
module nvm_reg_bank
    import nvm_fault_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output ctrl_cfg_t         cfg_q,
    output fault_pair_t       en_q,
    output fault_pair_t       clr_req
);

    reg_sel_t sel;

    always_comb begin
        sel = reg_sel(int'(reg_addr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_q  <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_CTRL) cfg_q <= ctrl_from_byte(reg_wdata);
            if (sel == SEL_EN)   en_q  <= pair_from_byte(reg_wdata);
        end
    end

    always_comb begin
        clr_req = '0;
        if (reg_wr && sel == SEL_STAT) clr_req = pair_from_byte(reg_wdata);
    end

endmodule

// File: rtl/nvm_fault_flags.sv
module nvm_fault_flags
    import nvm_fault_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_strobe,
    input  logic        ecc_single,
    input  logic        ecc_double,
    input  logic        ign_single,
    input  logic        force_single,
    input  logic        force_double,
    input  fault_pair_t clr_req,
    output fault_pair_t flags_q
);

    fault_pair_t set_req;

    always_comb begin
        set_req.sgl = rd_strobe && (force_single || (ecc_single && !ign_single));
        set_req.dbl = rd_strobe && (force_double || ecc_double);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            // a set in the same cycle overrides the clear
            flags_q <= (flags_q & ~clr_req) | set_req;
        end
    end

endmodule

// File: rtl/nvm_irq_out.sv
module nvm_irq_out #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq_q
);

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) irq_q[i] <= 1'b0;
            else     irq_q[i] <= src[i] & en[i];
        end
    end

endmodule

// File: rtl/nvm_fault_irq_ctrl.sv
module nvm_fault_irq_ctrl
    import nvm_fault_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rd_strobe,
    input  logic              ecc_single,
    input  logic              ecc_double,
    input  logic              cmd_done,
    output logic              irq_cmd,
    output logic              irq_single,
    output logic              irq_double
);

    ctrl_cfg_t        cfg_q;
    fault_pair_t      en_q;
    fault_pair_t      clr_req;
    fault_pair_t      flags_q;
    logic [IRQ_N-1:0] irq_src;
    logic [IRQ_N-1:0] irq_en;
    logic [IRQ_N-1:0] irq_q;

    nvm_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .cfg_q    (cfg_q),
        .en_q     (en_q),
        .clr_req  (clr_req)
    );

    nvm_fault_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .rd_strobe   (rd_strobe),
        .ecc_single  (ecc_single),
        .ecc_double  (ecc_double),
        .ign_single  (cfg_q.ign_single),
        .force_single(cfg_q.force_single),
        .force_double(cfg_q.force_double),
        .clr_req     (clr_req),
        .flags_q     (flags_q)
    );

    always_comb begin
        irq_src          = '0;
        irq_en           = '0;
        irq_src[IRQ_CMD] = cmd_done;
        irq_en[IRQ_CMD]  = cfg_q.cmd_ie;
        irq_src[IRQ_SGL] = flags_q.sgl;
        irq_en[IRQ_SGL]  = en_q.sgl;
        irq_src[IRQ_DBL] = flags_q.dbl;
        irq_en[IRQ_DBL]  = en_q.dbl;
    end

    nvm_irq_out #(.N(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .src  (irq_src),
        .en   (irq_en),
        .irq_q(irq_q)
    );

    assign irq_cmd    = irq_q[IRQ_CMD];
    assign irq_single = irq_q[IRQ_SGL];
    assign irq_double = irq_q[IRQ_DBL];

    always_comb begin
        case (reg_sel(int'(reg_addr)))
            SEL_CTRL: reg_rdata = ctrl_to_byte(cfg_q);
            SEL_EN:   reg_rdata = pair_to_byte(en_q);
            SEL_STAT: reg_rdata = pair_to_byte(flags_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nvm_fault_irq_ctrl_chk.sv
module nvm_fault_irq_ctrl_chk
    import nvm_fault_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              rd_strobe,
    input logic              ecc_single,
    input logic              ecc_double,
    input logic              cmd_done,
    input logic              irq_cmd,
    input logic              irq_single,
    input logic              irq_double,
    input ctrl_cfg_t         cfg_q,
    input fault_pair_t       en_q,
    input fault_pair_t       flags_q
);

    logic wr_ctrl, wr_stat;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_SLOT));
    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(STAT_SLOT));

    // R1
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(CTRL_SLOT)) |-> ((reg_rdata & 8'h6C) == 8'h00));

    // R1
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (cfg_q == ctrl_from_byte($past(reg_wdata))));

    // R3
    cmd_irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.cmd_ie |=> !irq_cmd);

    // R3
    cmd_irq_on_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.cmd_ie && cmd_done) |=> irq_cmd);

    // R4
    ign_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && ecc_single && cfg_q.ign_single && !cfg_q.force_single && !flags_q.sgl)
        |=> !flags_q.sgl);

    // R5
    force_double_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && cfg_q.force_double) |=> flags_q.dbl);

    // R6
    w1c_single_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[SGL_BIT] && !rd_strobe) |=> !flags_q.sgl);

    // R7
    sgl_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_single == $past(flags_q.sgl && en_q.sgl));

    // R7
    dbl_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_double == $past(flags_q.dbl && en_q.dbl));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && ecc_double && wr_stat && reg_wdata[DBL_BIT]) |=> flags_q.dbl);

    // R10
    force_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.force_single && !(wr_ctrl && !reg_wdata[FORCE_SG_BIT])) |=> cfg_q.force_single);

endmodule

bind nvm_fault_irq_ctrl nvm_fault_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nvm_fault_irq_ctrl_tb.sv
`timescale 1ns/100ps
module nvm_fault_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rd_strobe = 1'b0;
    logic       ecc_single = 1'b0;
    logic       ecc_double = 1'b0;
    logic       cmd_done = 1'b0;
    logic       irq_cmd, irq_single, irq_double;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic m_cie, m_ign, m_fd, m_fs;
    logic m_en_d, m_en_s, m_fl_d, m_fl_s;
    logic m_irq_c, m_irq_s, m_irq_d;

    always #2.5 clk = ~clk;

    nvm_fault_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_strobe(rd_strobe),
        .ecc_single(ecc_single), .ecc_double(ecc_double), .cmd_done(cmd_done),
        .irq_cmd(irq_cmd), .irq_single(irq_single), .irq_double(irq_double)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_cie, 2'b00, m_ign, 2'b00, m_fd, m_fs};
            2'd1:    return {6'b0, m_en_d, m_en_s};
            2'd2:    return {6'b0, m_fl_d, m_fl_s};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R1";
            2'd1:    return "R8";
            2'd2:    return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_cie, m_ign, m_fd, m_fs} = '0;
        {m_en_d, m_en_s, m_fl_d, m_fl_s} = '0;
        {m_irq_c, m_irq_s, m_irq_d} = '0;
    endtask

    // one cycle: drive, check read data, clock edge, update model, check irqs
    task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                        input logic rs, input logic es, input logic ed, input logic cd,
                        input bit use_k, input logic [7:0] k, input string ktag);
        logic set_s, set_d, clr_s, clr_d;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        rd_strobe = rs; ecc_single = es; ecc_double = ed; cmd_done = cd;
        #1;
        chk(rd_tag(a), reg_rdata, exp_read(a));
        if (use_k) chk(ktag, reg_rdata, k);
        @(posedge clk);
        m_irq_c = cd & m_cie;
        m_irq_s = m_fl_s & m_en_s;
        m_irq_d = m_fl_d & m_en_d;
        set_s = rs & (m_fs | (es & ~m_ign));
        set_d = rs & (m_fd | ed);
        clr_s = wr && a == 2'd2 && wd[0];
        clr_d = wr && a == 2'd2 && wd[1];
        m_fl_s = (m_fl_s & ~clr_s) | set_s;
        m_fl_d = (m_fl_d & ~clr_d) | set_d;
        if (wr && a == 2'd0) {m_cie, m_ign, m_fd, m_fs} = {wd[7], wd[4], wd[1], wd[0]};
        if (wr && a == 2'd1) {m_en_d, m_en_s} = wd[1:0];
        #1;
        chk("R3", {7'b0, irq_cmd}, {7'b0, m_irq_c});
        chk("R7", {7'b0, irq_single}, {7'b0, m_irq_s});
        chk("R7", {7'b0, irq_double}, {7'b0, m_irq_d});
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "");
    endtask

    task automatic rd_k(input logic [1:0] a, input logic [7:0] k, input string tag);
        step(1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, k, tag);
    endtask

    task automatic rd_event(input logic es, input logic ed);
        step(1'b0, 2'd2, 8'h00, 1'b1, es, ed, 1'b0, 1'b0, 8'h00, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        rd_k(2'd0, 8'h00, "R2");
        rd_k(2'd1, 8'h00, "R2");
        rd_k(2'd2, 8'h00, "R2");
        chk("R2", {5'b0, irq_cmd, irq_single, irq_double}, 8'h00);

        // R1: reserved control bits
        wr_reg(2'd0, 8'hFF);
        rd_k(2'd0, 8'h93, "R1");
        wr_reg(2'd0, 8'h00);
        rd_k(2'd0, 8'h00, "R1");

        // R8: enable register
        wr_reg(2'd1, 8'hFF);
        rd_k(2'd1, 8'h03, "R8");

        // R11: unused slot
        wr_reg(2'd3, 8'hFF);
        rd_k(2'd3, 8'h00, "R11");
        rd_k(2'd0, 8'h00, "R11");

        // R4: no strobe, no effect
        step(1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "");
        rd_k(2'd2, 8'h00, "R4");
        // R4: ignore set
        wr_reg(2'd0, 8'h10);
        rd_event(1'b1, 1'b0);
        rd_k(2'd2, 8'h00, "R4");
        // R4: ignore clear
        wr_reg(2'd0, 8'h00);
        rd_event(1'b1, 1'b0);
        rd_k(2'd2, 8'h01, "R4");
        chk("R7", {7'b0, irq_single}, 8'h01);

        // R6: write 0 no effect, write 1 clears
        wr_reg(2'd2, 8'h00);
        rd_k(2'd2, 8'h01, "R6");
        wr_reg(2'd2, 8'h01);
        rd_k(2'd2, 8'h00, "R6");

        // R5 / R10: force double persists
        wr_reg(2'd0, 8'h02);
        for (int i = 0; i < 3; i++) begin
            rd_event(1'b0, 1'b0);
            rd_k(2'd2, 8'h02, "R5");
            wr_reg(2'd2, 8'h02);
        end
        rd_k(2'd0, 8'h02, "R10");
        wr_reg(2'd0, 8'h00);
        rd_k(2'd0, 8'h00, "R10");
        rd_event(1'b0, 1'b0);
        rd_k(2'd2, 8'h00, "R5");

        // R5: force single overrides ignore
        wr_reg(2'd0, 8'h11);
        rd_event(1'b0, 1'b0);
        rd_k(2'd2, 8'h01, "R5");
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd2, 8'h03);

        // R9: set wins over clear
        rd_event(1'b0, 1'b1);
        step(1'b1, 2'd2, 8'h02, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "");
        rd_k(2'd2, 8'h02, "R9");
        wr_reg(2'd2, 8'h03);

        // R3: command interrupt
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "");
        chk("R3", {7'b0, irq_cmd}, 8'h00);
        wr_reg(2'd0, 8'h80);
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "");
        chk("R3", {7'b0, irq_cmd}, 8'h01);

        // random traffic
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic wr;
            logic [1:0] a;
            logic [7:0] wd;
            wr = ($urandom % 8) == 0;
            a  = 2'($urandom);
            wd = 8'($urandom);
            step(wr, a, wd, ($urandom % 3) != 0, ($urandom % 4) == 0,
                 ($urandom % 6) == 0, 1'($urandom), 1'b0, 8'h00, "");
        end

        finish_run();
    end

endmodule